// File: doc/BRIEF.md
# Double-Buffered Byte-Lane DAC Code Register

This block is the digital front end of a 16-bit parallel-load converter, modelled with a fast system clock. A host writes a 16-bit code through two byte lanes. The low lane and the high lane each have their own active-low select, and both share one active-low write strobe. The written value lands in an input register. A separate active-low load strobe then moves that value into the DAC register, and the DAC register drives the converter code output.

Both registers act as level-transparent latches. Each follows its source while its strobe is low and keeps its value once the strobe rises. If the selects, the write strobe and the load strobe are all low together, a change on the data bus reaches the code output directly. Before use, the asynchronous host controls and the data bus pass through two-stage synchronizers, so an input reaches the output on the third rising clock edge.

An active-low clear overrides every other input and forces both registers to a preset value. A second pin chooses that value: midscale or zero. Power-on reset gives the same preset. A one-cycle update pulse marks each change of the DAC register.

Top module: `dac_dbuf_front`

## Requirements
- R1: While `wr_n` is 0 and `lo_sel_n` is 0, input-register bits 7:0 follow `data_i[7:0]`; at other times they keep their value.
- R2: While `wr_n` is 0 and `hi_sel_n` is 0, input-register bits 15:8 follow `data_i[15:8]`; at other times they keep their value.
- R3: The two lanes can be written in either order, and both selects low together load all 16 bits at once.
- R4: While `ld_n` is 0, the DAC register follows the input register whatever the selects are; while `ld_n` is 1 it keeps its value.
- R5: With both selects, `wr_n` and `ld_n` all low, every change on `data_i` appears on `code_o` (write-through).
- R6: With one select low together with `wr_n` and `ld_n`, that lane passes straight to `code_o` and the other lane keeps its held input-register value.
- R7: `clr_n` at 0 forces `code_o` at once, without a clock, to 0x8000 when `mid_sel` is 1 or to 0x0000 when `mid_sel` is 0, and it loads the same value into both registers; it overrides all other inputs.
- R8: After power-on reset (`rst_n` low), `code_o` and both registers hold the `mid_sel` preset (0x8000 or 0x0000).
- R9: With `wr_n` and `ld_n` both 1, or with both selects and `ld_n` at 1, `code_o` does not change whatever is on `data_i`.
- R10: `upd_o` is high for exactly one cycle for each change of the DAC register, and is low otherwise.
- R11: A control or data change driven between two rising edges appears on `code_o` after the third rising edge that follows, not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the host interface |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| data_i | input | 16 | Parallel data bus, high lane in bits 15:8 |
| lo_sel_n | input | 1 | Active-low select for lane bits 7:0 |
| hi_sel_n | input | 1 | Active-low select for lane bits 15:8 |
| wr_n | input | 1 | Active-low write strobe for the input register |
| ld_n | input | 1 | Active-low load strobe for the DAC register |
| clr_n | input | 1 | Active-low asynchronous clear |
| mid_sel | input | 1 | Clear/reset preset: 1 gives midscale, 0 gives zero |
| code_o | output | 16 | DAC register code driven to the converter |
| upd_o | output | 1 | One-cycle pulse on each DAC register change |

## Verification
The bench applies every combination of the two selects, the write strobe and the load strobe over several data patterns, and a bit-level model predicts each result. A design that mixed up lane ownership, or that gated the load on a select, would show the wrong byte or a stale code. After a clear it writes a single lane and then performs a load alone; a clear that reset only the DAC register would show the old high byte instead of the preset. It checks that the output moves the instant the clear pin falls, and that the output is still the old code after two edges and has changed after three. A synchronizer of the wrong depth, or an output registered twice, fails that latency probe.

// File: rtl/dac_dbuf_front.sv
module dac_dbuf_front #(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] data_i,
  input  logic              lo_sel_n,
  input  logic              hi_sel_n,
  input  logic              wr_n,
  input  logic              ld_n,
  input  logic              clr_n,
  input  logic              mid_sel,
  output logic [DATA_W-1:0] code_o,
  output logic              upd_o
);
  localparam int HALF       = DATA_W / 2;
  localparam int LANES      = 2;
  localparam int CTL_W      = 5;
  localparam int CLR_STAGES = SYNC_STAGES + 1;
  localparam logic [DATA_W-1:0] MID_CODE = DATA_W'(1) << (DATA_W - 1);

  logic [CTL_W-1:0]  ctl_pipe [SYNC_STAGES];
  logic [DATA_W-1:0] dat_pipe [SYNC_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) begin
        ctl_pipe[i] <= '1;
        dat_pipe[i] <= '0;
      end
    end else begin
      ctl_pipe[0] <= {mid_sel, ld_n, wr_n, hi_sel_n, lo_sel_n};
      dat_pipe[0] <= data_i;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        ctl_pipe[i] <= ctl_pipe[i-1];
        dat_pipe[i] <= dat_pipe[i-1];
      end
    end
  end

  logic [LANES-1:0]  sel_s;
  logic              wr_s, ld_s, mid_s;
  logic [DATA_W-1:0] din_s;
  assign sel_s = ctl_pipe[SYNC_STAGES-1][1:0];
  assign wr_s  = ctl_pipe[SYNC_STAGES-1][2];
  assign ld_s  = ctl_pipe[SYNC_STAGES-1][3];
  assign mid_s = ctl_pipe[SYNC_STAGES-1][4];
  assign din_s = dat_pipe[SYNC_STAGES-1];

  // clear chain: asserted asynchronously, released after the control pipe refills
  logic                  clr_arst_n;
  logic [CLR_STAGES-1:0] clr_pipe;
  logic                  clr_act;
  assign clr_arst_n = rst_n & clr_n;

  always_ff @(posedge clk or negedge clr_arst_n) begin
    if (!clr_arst_n) clr_pipe <= '0;
    else             clr_pipe <= {clr_pipe[CLR_STAGES-2:0], 1'b1};
  end
  assign clr_act = ~clr_pipe[CLR_STAGES-1];

  logic [DATA_W-1:0] in_q, in_nx, dac_q, dac_nx, clr_val_s, clr_val_raw;
  logic              upd_q;
  assign clr_val_s   = mid_s   ? MID_CODE : '0;
  assign clr_val_raw = mid_sel ? MID_CODE : '0;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign in_nx[g*HALF +: HALF] = (!wr_s && !sel_s[g]) ? din_s[g*HALF +: HALF]
                                                        : in_q[g*HALF +: HALF];
  end

  assign dac_nx = ld_s ? dac_q : in_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q  <= '0;
      dac_q <= '0;
      upd_q <= 1'b0;
    end else if (clr_act) begin
      in_q  <= clr_val_s;
      dac_q <= clr_val_s;
      upd_q <= (dac_q != clr_val_s);
    end else begin
      in_q  <= in_nx;
      dac_q <= dac_nx;
      upd_q <= (dac_nx != dac_q);
    end
  end

  assign code_o = clr_act ? clr_val_raw : dac_q;
  assign upd_o  = upd_q;

  p_lo_follow_r1: assert property (@(posedge clk) disable iff (!rst_n || clr_act)
    (!wr_s && !sel_s[0]) |=> (in_q[HALF-1:0] == $past(din_s[HALF-1:0])));

  p_hi_follow_r2: assert property (@(posedge clk) disable iff (!rst_n || clr_act)
    (!wr_s && !sel_s[1]) |=> (in_q[DATA_W-1:HALF] == $past(din_s[DATA_W-1:HALF])));

  p_dac_hold_r4: assert property (@(posedge clk) disable iff (!rst_n || clr_act)
    ld_s |=> (dac_q == $past(dac_q)));

  p_input_hold_r9: assert property (@(posedge clk) disable iff (!rst_n || clr_act)
    wr_s |=> (in_q == $past(in_q)));

  p_clear_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> (code_o == (mid_sel ? MID_CODE : '0)));

  p_upd_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |-> (dac_q != $past(dac_q)));

endmodule

// File: tb/dac_dbuf_front_test.sv
module dac_dbuf_front_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] data_i;
  logic        lo_sel_n, hi_sel_n, wr_n, ld_n, clr_n, mid_sel;
  logic [15:0] code_o;
  logic        upd_o;

  int vecs = 0;
  int bad  = 0;
  int upd_cnt = 0;
  logic [15:0] in_m, dac_m;

  always #2 clk = ~clk;

  dac_dbuf_front uut (
    .clk(clk), .rst_n(rst_n), .data_i(data_i), .lo_sel_n(lo_sel_n),
    .hi_sel_n(hi_sel_n), .wr_n(wr_n), .ld_n(ld_n), .clr_n(clr_n),
    .mid_sel(mid_sel), .code_o(code_o), .upd_o(upd_o)
  );

  always @(negedge clk) if (upd_o) upd_cnt++;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  endtask

  task automatic idle();
    lo_sel_n = 1'b1; hi_sel_n = 1'b1; wr_n = 1'b1; ld_n = 1'b1;
  endtask

  // one stimulus row, checked against a bit-level model, then return to idle
  task automatic step(input logic lo, input logic hi, input logic wr,
                      input logic ld, input logic [15:0] d, input string req);
    logic [15:0] old_dac;
    old_dac = dac_m;
    upd_cnt = 0;
    data_i = d; lo_sel_n = lo; hi_sel_n = hi; wr_n = wr; ld_n = ld;
    tick(4);
    if (!wr && !lo) in_m[7:0]  = d[7:0];
    if (!wr && !hi) in_m[15:8] = d[15:8];
    if (!ld) dac_m = in_m;
    check(req, code_o, dac_m);
    check("R10", 16'(upd_cnt), (dac_m != old_dac) ? 16'd1 : 16'd0);
    upd_cnt = 0;
    idle();
    tick(4);
    check(req, code_o, dac_m);
    check("R10", 16'(upd_cnt), 16'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; clr_n = 1'b1; mid_sel = 1'b1; data_i = 16'h0;
    idle();
    tick(3);
    check("R8", code_o, 16'h8000);
    check("R10", {15'd0, upd_o}, 16'd0);
    rst_n = 1'b1;
    tick(6);
    check("R8", code_o, 16'h8000);
    in_m = 16'h8000; dac_m = 16'h8000;
    step(1, 1, 1, 0, 16'h1357, "R8");

    // exhaustive strobe/select sweep
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 16; k++) begin
        logic [15:0] d;
        d = 16'((k * 40503 + p * 4099) ^ 16'h5AA5);
        step(k[0], k[1], k[2], k[3], d,
             (k[3] && k[2]) ? "R9" : (k == 0) ? "R3" : (!k[2] && !k[3]) ? "R6" :
             !k[3] ? "R4" : (k[0] ? "R2" : "R1"));
      end
    end

    // bytes in either order, then load
    step(0, 1, 0, 1, 16'hEE21, "R1");
    step(1, 0, 0, 1, 16'h43EE, "R2");
    step(1, 1, 1, 0, 16'h0000, "R3");
    step(1, 0, 0, 1, 16'h9AFF, "R3");
    step(0, 1, 0, 1, 16'hFFBC, "R3");
    step(1, 1, 1, 0, 16'h0000, "R3");

    // write-through following a moving bus, with latency probe
    data_i = 16'hA5C3; lo_sel_n = 0; hi_sel_n = 0; wr_n = 0; ld_n = 0;
    tick(2);
    check("R11", code_o, dac_m);
    tick(1);
    check("R11", code_o, 16'hA5C3);
    data_i = 16'h3C5A;
    tick(3);
    check("R5", code_o, 16'h3C5A);
    data_i = 16'hFFFF;
    tick(3);
    check("R5", code_o, 16'hFFFF);
    idle();
    tick(4);
    in_m = 16'hFFFF; dac_m = 16'hFFFF;
    check("R5", code_o, 16'hFFFF);

    // asynchronous clear to midscale
    clr_n = 1'b0;
    #1;
    check("R7", code_o, 16'h8000);
    data_i = 16'h7777; lo_sel_n = 0; hi_sel_n = 0; wr_n = 0; ld_n = 0;
    tick(4);
    check("R7", code_o, 16'h8000);
    idle();
    tick(4);
    clr_n = 1'b1;
    tick(6);
    check("R7", code_o, 16'h8000);
    in_m = 16'h8000; dac_m = 16'h8000;
    step(0, 1, 0, 1, 16'h1234, "R7");
    step(1, 1, 1, 0, 16'h0000, "R7");
    check("R7", code_o, 16'h8034);

    // asynchronous clear to zero
    mid_sel = 1'b0;
    tick(4);
    clr_n = 1'b0;
    #1;
    check("R7", code_o, 16'h0000);
    tick(4);
    clr_n = 1'b1;
    tick(6);
    check("R7", code_o, 16'h0000);
    in_m = 16'h0000; dac_m = 16'h0000;
    step(1, 0, 0, 1, 16'hAB77, "R7");
    step(1, 1, 1, 0, 16'h0000, "R7");
    check("R7", code_o, 16'hAB00);

    // power-on reset with zero preset
    rst_n = 1'b0;
    tick(2);
    check("R8", code_o, 16'h0000);
    rst_n = 1'b1;
    tick(6);
    check("R8", code_o, 16'h0000);
    in_m = 16'h0000; dac_m = 16'h0000;
    step(1, 1, 1, 0, 16'hFFFF, "R8");

    finish_run();
  end
endmodule